// File: doc/BRIEF.md
# Gated Dual Event Counter

This block holds two independent up-counters, called high and low, and each one counts transitions on its own external event pin. Every event pin has its own choice of active edge: rising, falling, or both. A counter can be frozen at its current value or held at zero without changing the other counter. When a counter rolls over from its top value back to zero, it sets a sticky overflow flag of its own. Any rollover also sets a shared counter interrupt request.

A common external gate pin can stall both counters at once. In gated mode an event is counted only while the synchronized gate level is high. The gate pin is also a second interrupt source with its own edge choice, request flag and enable. It raises its request on the chosen edge whether or not gating is in use.

Software controls the block through four write strobes, each with a data word. These cover edge and gate configuration, run control, write-zero flag clearing and interrupt enables. All external pins pass through a two-flop synchronizer before edge detection, and a counter advances at most once per system clock.

Top module: `gated_evt_cnt`

## Requirements
- R1: After reset both counters read 0, and all four flags (ovHi, ovLo, cntReq, gateReq) and both interrupt outputs read 0.
- R2: An enabled counter whose clear is released adds one for each selected edge of its event pin. The edge codes are 00 rising, 01 falling, 10 both, 11 treated as rising. The high counter's code is cfgData[1:0] and the low counter's code is cfgData[3:2].
- R3: An edge on an event pin, applied between clock edges, shows up on the counter output after the third rising clock edge that follows it, and not before.
- R4: A counter that takes an event while at its all-ones value goes to 0 and sets its own overflow flag (ovHi or ovLo). The flag stays at 1 until it is cleared.
- R5: runData bit 0 enables the high counter and bit 1 enables the low counter. A disabled counter keeps its value. runData bit 2 (high) and bit 3 (low) are active-low clears, and a clear at 0 holds its counter at 0.
- R6: With cfgData[6] at 0, neither counter advances while the synchronized gate pin is low. With cfgData[6] at 1, the gate pin has no effect on counting.
- R7: A rollover of either counter sets cntReq. cntIrq is 1 only while both cntReq and irqEnData bit 0 are 1.
- R8: The gate pin sets gateReq on the edge chosen by cfgData[5:4], using the same codes as R2, in either gate mode. gateIrq is 1 only while both gateReq and irqEnData bit 1 are 1.
- R9: A flag-clear write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. The bit order is 0 ovHi, 1 ovLo, 2 cntReq, 3 gateReq. If a flag is cleared and set in the same cycle, it ends up set.
- R10: Events on one counter's pin, and the run settings of one counter, leave the other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtHiIn | input | 1 | Event pin of the high counter |
| evtLoIn | input | 1 | Event pin of the low counter |
| gateIn | input | 1 | Shared gate pin and gate interrupt source |
| cfgWr | input | 1 | Write strobe for edge and gate configuration |
| cfgData | input | 8 | [1:0] high edge, [3:2] low edge, [5:4] gate edge, [6] gate bypass |
| runWr | input | 1 | Write strobe for run control |
| runData | input | 4 | [0] high enable, [1] low enable, [2] high clear_n, [3] low clear_n |
| flagClrWr | input | 1 | Write strobe for write-zero flag clearing |
| flagClrData | input | 4 | 0 clears: [0] ovHi, [1] ovLo, [2] cntReq, [3] gateReq |
| irqEnWr | input | 1 | Write strobe for interrupt enables |
| irqEnData | input | 2 | [0] counter interrupt enable, [1] gate interrupt enable |
| cntHi | output | 8 | High counter value |
| cntLo | output | 8 | Low counter value |
| ovHi | output | 1 | Sticky overflow flag of the high counter |
| ovLo | output | 1 | Sticky overflow flag of the low counter |
| cntReq | output | 1 | Shared counter interrupt request flag |
| gateReq | output | 1 | Gate-pin interrupt request flag |
| cntIrq | output | 1 | Counter interrupt to the processor |
| gateIrq | output | 1 | Gate interrupt to the processor |

## Verification
The counting path is swept over all sixteen pairs of high and low edge codes, with a different number of pulses on each pin. A pulse counted once, twice or not at all therefore exposes a wrong edge decode or one counter leaking into the other. Long pulse trains drive each counter through rollover to separate wrap, flag and interrupt-gating errors. The gate pin is tried both as a level, low then high, with and without bypass, and as an edge source under all four codes. A clear is timed to land in the same cycle as a rollover, to pin down which of the two takes priority. A single edge is also sampled cycle by cycle to fix the synchronizer latency.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;

  localparam int NUM_CNT   = 2;
  localparam int NUM_PINS  = NUM_CNT + 1;
  localparam int NUM_FLAGS = 4;

  localparam int FLAG_OV_HI    = 0;
  localparam int FLAG_OV_LO    = 1;
  localparam int FLAG_CNT_REQ  = 2;
  localparam int FLAG_GATE_REQ = 3;

  typedef struct packed {
    logic [NUM_CNT-1:0]   inc;
    logic [NUM_CNT-1:0]   zero;
    logic                 gateEvt;
    logic [NUM_FLAGS-1:0] clrFlag;
    logic [1:0]           irqEn;
  } evc_stb_t;

endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       asyncIn,
  input  logic [1:0] edgeSel,
  output logic       level,
  output logic       hit
);
  import evc_pkg::*;

  logic [STAGES:0] chain;
  logic            prevLevel;
  logic            rise;
  logic            fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], asyncIn};
  end

  assign level     = chain[STAGES-1];
  assign prevLevel = chain[STAGES];
  assign rise      = level & ~prevLevel;
  assign fall      = ~level & prevLevel;

  always_comb begin
    unique case (edge_sel_e'(edgeSel))
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = rise;
    endcase
  end

endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtHiIn,
  input  logic               evtLoIn,
  input  logic               gateIn,
  input  logic               cfgWr,
  input  logic [7:0]         cfgData,
  input  logic               runWr,
  input  logic [3:0]         runData,
  input  logic               flagClrWr,
  input  logic [3:0]         flagClrData,
  input  logic               irqEnWr,
  input  logic [1:0]         irqEnData,
  output evc_pkg::evc_stb_t  stb
);
  import evc_pkg::*;

  logic [6:0]           cfgReg;
  logic [NUM_CNT-1:0]   runEn;
  logic [NUM_CNT-1:0]   clrN;
  logic [1:0]           irqEnReg;
  logic [NUM_PINS-1:0]  pinIn;
  logic [NUM_PINS-1:0]  pinLevel;
  logic [NUM_PINS-1:0]  pinHit;
  logic [NUM_CNT-1:0]   incBits;
  logic                 gateOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      runEn    <= '0;
      clrN     <= '0;
      irqEnReg <= '0;
    end else begin
      if (cfgWr)   cfgReg   <= cfgData[6:0];
      if (runWr)   begin
        runEn <= runData[1:0];
        clrN  <= runData[3:2];
      end
      if (irqEnWr) irqEnReg <= irqEnData;
    end
  end

  assign pinIn = {gateIn, evtLoIn, evtHiIn};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    evc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (pinIn[p]),
      .edgeSel (cfgReg[2*p +: 2]),
      .level   (pinLevel[p]),
      .hit     (pinHit[p])
    );
  end

  assign gateOpen = cfgReg[6] | pinLevel[NUM_PINS-1];

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_inc
    assign incBits[c] = pinHit[c] & runEn[c] & gateOpen;
  end

  always_comb begin
    stb         = '0;
    stb.inc     = incBits;
    stb.zero    = ~clrN;
    stb.gateEvt = pinHit[NUM_PINS-1];
    stb.clrFlag = flagClrWr ? ~flagClrData : '0;
    stb.irqEn   = irqEnReg;
  end

endmodule

// File: rtl/evc_dp.sv
module evc_dp #(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  evc_pkg::evc_stb_t stb,
  output logic [CNT_W-1:0]  cntHi,
  output logic [CNT_W-1:0]  cntLo,
  output logic              ovHi,
  output logic              ovLo,
  output logic              cntReq,
  output logic              gateReq,
  output logic              cntIrq,
  output logic              gateIrq
);
  import evc_pkg::*;

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [NUM_CNT-1:0] wrap;
  logic [NUM_CNT-1:0] ovFlag;

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    assign wrap[c] = stb.inc[c] & ~stb.zero[c] & (cnt[c] == CNT_TOP);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt[c] <= '0;
      else if (stb.zero[c]) cnt[c] <= '0;
      else if (stb.inc[c])  cnt[c] <= cnt[c] + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               ovFlag[c] <= 1'b0;
      else if (wrap[c])        ovFlag[c] <= 1'b1;
      else if (stb.clrFlag[c]) ovFlag[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cntReq <= 1'b0;
    else if (|wrap)                     cntReq <= 1'b1;
    else if (stb.clrFlag[FLAG_CNT_REQ]) cntReq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           gateReq <= 1'b0;
    else if (stb.gateEvt)                gateReq <= 1'b1;
    else if (stb.clrFlag[FLAG_GATE_REQ]) gateReq <= 1'b0;
  end

  assign cntHi   = cnt[0];
  assign cntLo   = cnt[1];
  assign ovHi    = ovFlag[FLAG_OV_HI];
  assign ovLo    = ovFlag[FLAG_OV_LO];
  assign cntIrq  = cntReq & stb.irqEn[0];
  assign gateIrq = gateReq & stb.irqEn[1];

endmodule

// File: rtl/gated_evt_cnt.sv
module gated_evt_cnt #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtHiIn,
  input  logic             evtLoIn,
  input  logic             gateIn,
  input  logic             cfgWr,
  input  logic [7:0]       cfgData,
  input  logic             runWr,
  input  logic [3:0]       runData,
  input  logic             flagClrWr,
  input  logic [3:0]       flagClrData,
  input  logic             irqEnWr,
  input  logic [1:0]       irqEnData,
  output logic [CNT_W-1:0] cntHi,
  output logic [CNT_W-1:0] cntLo,
  output logic             ovHi,
  output logic             ovLo,
  output logic             cntReq,
  output logic             gateReq,
  output logic             cntIrq,
  output logic             gateIrq
);
  import evc_pkg::*;

  evc_stb_t stb;

  evc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evtHiIn     (evtHiIn),
    .evtLoIn     (evtLoIn),
    .gateIn      (gateIn),
    .cfgWr       (cfgWr),
    .cfgData     (cfgData),
    .runWr       (runWr),
    .runData     (runData),
    .flagClrWr   (flagClrWr),
    .flagClrData (flagClrData),
    .irqEnWr     (irqEnWr),
    .irqEnData   (irqEnData),
    .stb         (stb)
  );

  evc_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cntHi   (cntHi),
    .cntLo   (cntLo),
    .ovHi    (ovHi),
    .ovLo    (ovLo),
    .cntReq  (cntReq),
    .gateReq (gateReq),
    .cntIrq  (cntIrq),
    .gateIrq (gateIrq)
  );

endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input evc_pkg::evc_stb_t stb,
  input logic [CNT_W-1:0]  cntHi,
  input logic [CNT_W-1:0]  cntLo,
  input logic              ovHi,
  input logic              ovLo,
  input logic              cntReq,
  input logic              gateReq,
  input logic              cntIrq,
  input logic              gateIrq
);

  a_r2_step_hi: assert property (@(posedge clk) disable iff (!rstN)
    !stb.zero[0] |=> (cntHi == $past(cntHi) || cntHi == CNT_W'($past(cntHi) + 1'b1)));

  a_r10_step_lo: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.zero[1] && !stb.inc[1]) |=> (cntLo == $past(cntLo)));

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.zero[0] |=> (cntHi == '0));

  a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc[0] && !stb.zero[0] && cntHi == '1) |=> (cntHi == '0 && ovHi && cntReq));

  a_r9_sticky_ov: assert property (@(posedge clk) disable iff (!rstN)
    (ovLo && !stb.clrFlag[1]) |=> ovLo);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cntIrq) |-> (cntReq && stb.irqEn[0]));

  a_r8_gate_req: assert property (@(posedge clk) disable iff (!rstN)
    stb.gateEvt |=> gateReq);

  a_r8_gate_irq: assert property (@(posedge clk) disable iff (!rstN)
    !gateReq |-> !gateIrq);

endmodule

bind gated_evt_cnt evc_checker #(.CNT_W(CNT_W)) u_evc_checker (
  .clk     (clk),
  .rstN    (rstN),
  .stb     (stb),
  .cntHi   (cntHi),
  .cntLo   (cntLo),
  .ovHi    (ovHi),
  .ovLo    (ovLo),
  .cntReq  (cntReq),
  .gateReq (gateReq),
  .cntIrq  (cntIrq),
  .gateIrq (gateIrq)
);

// File: tb/test_gated_evt_cnt.sv
`timescale 1ns/1ps
module test_gated_evt_cnt;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evtHiIn = 1'b0, evtLoIn = 1'b0, gateIn = 1'b0;
  logic       cfgWr = 1'b0, runWr = 1'b0, flagClrWr = 1'b0, irqEnWr = 1'b0;
  logic [7:0] cfgData = '0;
  logic [3:0] runData = '0;
  logic [3:0] flagClrData = '1;
  logic [1:0] irqEnData = '0;
  logic [7:0] cntHi, cntLo;
  logic       ovHi, ovLo, cntReq, gateReq, cntIrq, gateIrq;

  int  nChk = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  gated_evt_cnt i_gated_evt_cnt (
    .clk(clk), .rstN(rstN), .evtHiIn(evtHiIn), .evtLoIn(evtLoIn), .gateIn(gateIn),
    .cfgWr(cfgWr), .cfgData(cfgData), .runWr(runWr), .runData(runData),
    .flagClrWr(flagClrWr), .flagClrData(flagClrData), .irqEnWr(irqEnWr),
    .irqEnData(irqEnData), .cntHi(cntHi), .cntLo(cntLo), .ovHi(ovHi), .ovLo(ovLo),
    .cntReq(cntReq), .gateReq(gateReq), .cntIrq(cntIrq), .gateIrq(gateIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setPin(input int p, input logic v);
    case (p)
      0: evtHiIn = v;
      1: evtLoIn = v;
      default: gateIn = v;
    endcase
  endtask

  task automatic pulse(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); setPin(p, 1'b1);
      repeat (3) @(negedge clk);
      setPin(p, 1'b0);
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic wrCfg(input logic [7:0] d);
    @(negedge clk); cfgWr = 1'b1; cfgData = d;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  task automatic wrRun(input logic [3:0] d);
    @(negedge clk); runWr = 1'b1; runData = d;
    @(negedge clk); runWr = 1'b0;
  endtask

  task automatic wrClr(input logic [3:0] d);
    @(negedge clk); flagClrWr = 1'b1; flagClrData = d;
    @(negedge clk); flagClrWr = 1'b0; flagClrData = '1;
  endtask

  task automatic wrIrq(input logic [1:0] d);
    @(negedge clk); irqEnWr = 1'b1; irqEnData = d;
    @(negedge clk); irqEnWr = 1'b0;
  endtask

  function automatic int expCount(input int mode, input int n);
    return (mode == 2) ? (2 * n) % 256 : n % 256;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cntHi", cntHi, 0);
    chk("R1 cntLo", cntLo, 0);
    chk("R1 flags", {ovHi, ovLo, cntReq, gateReq, cntIrq, gateIrq}, 0);

    // R2 / R10: sweep all edge-code pairs
    for (int hm = 0; hm < 4; hm++) begin
      for (int lm = 0; lm < 4; lm++) begin
        wrCfg({1'b0, 1'b1, 2'b00, 2'(lm), 2'(hm)});
        wrRun(4'b0000);
        wrRun(4'b1111);
        pulse(0, hm + 2);
        chk($sformatf("R2 hi mode %0d", hm), cntHi, expCount(hm, hm + 2));
        chk($sformatf("R10 lo untouched by hi, mode %0d", lm), cntLo, 0);
        pulse(1, lm + 3);
        chk($sformatf("R2 lo mode %0d", lm), cntLo, expCount(lm, lm + 3));
        chk($sformatf("R10 hi untouched by lo, mode %0d", hm), cntHi, expCount(hm, hm + 2));
      end
    end

    // R3 latency, rising mode
    wrCfg(8'b0100_0000);
    wrRun(4'b0000);
    wrRun(4'b1111);
    c0 = cntHi;
    @(negedge clk); evtHiIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 no count after two clock edges", cntHi, c0);
    @(negedge clk);
    chk("R3 count after third clock edge", cntHi, c0 + 1);
    evtHiIn = 1'b0;
    settle();

    // R5 freeze and clear
    pulse(0, 4);
    chk("R5 pre-freeze", cntHi, 5);
    wrRun(4'b1110);
    pulse(0, 3);
    chk("R5 disabled counter frozen", cntHi, 5);
    wrRun(4'b1011);
    pulse(0, 2);
    pulse(1, 2);
    chk("R5 clear holds zero", cntHi, 0);
    chk("R10 lo counts while hi cleared", cntLo, 2);

    // R6 gating
    wrCfg(8'b0000_0000);
    wrRun(4'b0000);
    wrRun(4'b1111);
    gateIn = 1'b0; settle();
    pulse(0, 3); pulse(1, 3);
    chk("R6 gate low blocks hi", cntHi, 0);
    chk("R6 gate low blocks lo", cntLo, 0);
    gateIn = 1'b1; settle();
    pulse(0, 2); pulse(1, 4);
    chk("R6 gate high passes hi", cntHi, 2);
    chk("R6 gate high passes lo", cntLo, 4);
    gateIn = 1'b0; settle();
    wrCfg(8'b0100_0000);
    pulse(0, 3);
    chk("R6 bypass ignores gate", cntHi, 5);
    wrClr(4'b0000);

    // R4 / R7 overflow of hi, both-edge mode
    wrCfg(8'b0100_0010);
    wrRun(4'b0000);
    wrRun(4'b1111);
    pulse(0, 127);
    chk("R4 hi at 254", cntHi, 254);
    chk("R4 no overflow yet", ovHi, 0);
    @(negedge clk); evtHiIn = 1'b1; settle();
    chk("R4 hi at 255", cntHi, 255);
    evtHiIn = 1'b0; settle();
    chk("R4 hi wraps to 0", cntHi, 0);
    chk("R4 ovHi set", ovHi, 1);
    chk("R7 cntReq set", cntReq, 1);
    chk("R7 cntIrq masked", cntIrq, 0);
    pulse(0, 3);
    chk("R4 counting resumes, ovHi sticky", {ovHi, cntHi}, 256 + 6);
    wrIrq(2'b01);
    chk("R7 cntIrq enabled", cntIrq, 1);

    // R9 selective write-zero
    wrClr(4'b1011);
    chk("R9 cntReq cleared", cntReq, 0);
    chk("R9 ovHi kept", ovHi, 1);
    chk("R7 cntIrq drops with cntReq", cntIrq, 0);

    // R4 / R7 overflow of lo, rising mode
    pulse(1, 256);
    chk("R4 lo wraps", cntLo, 0);
    chk("R4 ovLo set", ovLo, 1);
    chk("R7 lo overflow sets cntReq", cntReq, 1);
    wrClr(4'b1100);
    chk("R9 ov flags cleared, cntReq kept", {ovHi, ovLo, cntReq}, 1);
    wrClr(4'b0000);

    // R9 set beats clear in the same cycle
    wrCfg(8'b0100_0000);
    wrRun(4'b0000);
    wrRun(4'b1111);
    pulse(0, 255);
    chk("R9 setup hi at 255", cntHi, 255);
    @(negedge clk); evtHiIn = 1'b1;
    @(negedge clk);
    @(negedge clk); flagClrWr = 1'b1; flagClrData = 4'b1110;
    @(negedge clk); flagClrWr = 1'b0; flagClrData = '1;
    chk("R9 set wins over clear", ovHi, 1);
    chk("R4 wrap at clear cycle", cntHi, 0);
    evtHiIn = 1'b0; settle();
    wrClr(4'b0000);

    // R8 gate interrupt edge sweep
    wrIrq(2'b00);
    for (int gm = 0; gm < 4; gm++) begin
      wrCfg({1'b0, 1'b1, 2'(gm), 4'b0000});
      wrClr(4'b0111);
      gateIn = 1'b1; settle();
      chk($sformatf("R8 gate rise, mode %0d", gm), gateReq, (gm != 1) ? 1 : 0);
      chk("R8 gateIrq masked", gateIrq, 0);
      wrClr(4'b0111);
      gateIn = 1'b0; settle();
      chk($sformatf("R8 gate fall, mode %0d", gm), gateReq, (gm == 1 || gm == 2) ? 1 : 0);
    end
    wrCfg(8'b0000_0000);
    wrClr(4'b0111);
    wrIrq(2'b10);
    gateIn = 1'b1; settle();
    chk("R8 gateReq in gated mode", gateReq, 1);
    chk("R8 gateIrq enabled", gateIrq, 1);
    chk("R7 cntIrq stays low", cntIrq, 0);
    gateIn = 1'b0; settle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule